// File: doc/BRIEF.md
# UART Transmit Queue with Ready and Interrupt Control

This block is the transmit side of a UART minus the serializer. The host writes bytes into a 32-entry byte queue with a write strobe. An external shift engine takes them one at a time through a pop handshake. The read data comes back one clock after an accepted pop. The block tracks how full the queue is and drives two things from that count: an active-low ready pin for a DMA engine or a polling host, and a transmit interrupt.

The ready pin has two meanings, chosen by a mode input. In single-transfer mode it is active only while the queue is completely empty. In block-transfer (DMA) mode it stays active while at least one slot is free.

The interrupt is armed by an enable input. It fires when the occupancy drops under a threshold picked by a 2-bit select, or when the enable rises while the occupancy is already under that threshold. It is withdrawn in three cases: a status read, the host refilling the queue up to the threshold, or the enable being removed.

Top module: `uart_txq_ctrl`

## Requirements
- R1: The queue accepts exactly 32 bytes (DEPTH) from an empty state before it counts as full.
- R2: An accepted pop returns the oldest stored byte on `pop_data`, with `pop_valid` high, in the following cycle; bytes leave in write order.
- R3: The threshold select maps 0 to 8, 1 to 16, 2 to 24 and 3 to 30 entries. With `irq_en` high, `tx_irq` goes high one clock after a cycle in which either of these holds: the occupancy moves from at or above the threshold to below it, or `irq_en` rises while the occupancy after that cycle is below the threshold.
- R4: A cycle with `stat_rd` high makes `tx_irq` low in the next cycle, even when that same cycle would otherwise set it.
- R5: A pending `tx_irq` drops one clock after the cycle in which host writes bring the occupancy up to the threshold or above it.
- R6: With `dma_mode` low, `tx_rdy_n` is low one clock after a cycle that leaves the queue empty, and high one clock after any cycle that leaves it non-empty.
- R7: With `dma_mode` high, `tx_rdy_n` is high only one clock after a cycle that leaves the queue full, and low otherwise.
- R8: A write while the queue is full is dropped and sets `tx_ovf`. The flag stays set until reset.
- R9: A pop request while the queue is empty returns nothing: `pop_valid` is low in the next cycle and the occupancy does not change.
- R10: `stat_code` reads 4'h2 while the transmit interrupt is pending and 4'h1 otherwise.
- R11: After synchronous reset the queue is empty, `tx_rdy_n` is low, and `tx_irq`, `tx_ovf` and `pop_valid` are low.
- R12: While `irq_en` is low, `tx_irq` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to enqueue |
| pop_req | input | 1 | Serializer requests the next byte |
| pop_data | output | 8 | Byte returned for an accepted pop |
| pop_valid | output | 1 | `pop_data` is valid this cycle |
| dma_mode | input | 1 | Selects the ready-pin meaning (1 = block transfer) |
| irq_en | input | 1 | Transmit interrupt enable |
| trig_sel | input | 2 | Threshold select |
| stat_rd | input | 1 | Status register read strobe |
| stat_code | output | 4 | Interrupt status code |
| tx_rdy_n | output | 1 | Active-low transmit ready |
| tx_irq | output | 1 | Transmit interrupt |
| tx_ovf | output | 1 | Sticky write-overflow flag |

## Verification
The interrupt has three causes that can coincide in one cycle: a set from a downward threshold crossing, a clear from a status read, and a clear from a refill. The bench forces a pop that crosses the threshold in the same cycle as a status read, and requires the interrupt to stay low (the read wins). It also pairs a pop with a write at the threshold so that the occupancy holds steady and neither set nor clear fires. A long randomized run then mixes all the strobes, with the threshold and mode changing between segments. Every cycle is judged against a queue-based model that applies the same precedence.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam logic [3:0] STAT_NONE = 4'h1;
  localparam logic [3:0] STAT_TXE  = 4'h2;

  // Threshold in entries for a 2-bit select, scaled to the queue depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/txq_occ.sv
module txq_occ #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          pop_req,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  logic full, empty;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign push  = wr_req && !full;
  assign pop   = pop_req && !empty;

  always_comb begin
    case ({push, pop})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      cnt <= cnt_nxt;
      if (wr_req && full) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          dma_mode,
  input  logic          irq_en,
  input  logic [1:0]    trig_sel,
  input  logic          stat_rd,
  output logic          tx_rdy_n,
  output logic          tx_irq
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] trig;
  logic          below_nxt, crossing, en_rise, en_q, rdy_n_nxt;

  assign trig      = CW'(txq_pkg::trig_level(trig_sel, DEPTH));
  assign below_nxt = (cnt_nxt < trig);
  assign crossing  = (cnt >= trig) && below_nxt;
  assign en_rise   = irq_en && !en_q;
  assign rdy_n_nxt = dma_mode ? (cnt_nxt == FULL_CNT) : (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rdy_n <= 1'b0;
      tx_irq   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q     <= irq_en;
      tx_rdy_n <= rdy_n_nxt;
      if (stat_rd || !irq_en || !below_nxt)
        tx_irq <= 1'b0;
      else if (crossing || en_rise)
        tx_irq <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          pop_valid,
  input  logic          dma_mode,
  input  logic          irq_en,
  input  logic [1:0]    trig_sel,
  input  logic          stat_rd,
  output logic [3:0]    stat_code,
  output logic          tx_rdy_n,
  output logic          tx_irq,
  output logic          tx_ovf
);

  logic          push, pop;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ_cnt, occ_nxt;

  txq_occ #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_occ (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_en),
    .pop_req (pop_req),
    .push    (push),
    .pop     (pop),
    .wptr    (wptr),
    .rptr    (rptr),
    .cnt     (occ_cnt),
    .cnt_nxt (occ_nxt),
    .ovf     (tx_ovf)
  );

  txq_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (push),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (pop),
    .raddr (rptr),
    .rdata (pop_data)
  );

  txq_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .cnt      (occ_cnt),
    .cnt_nxt  (occ_nxt),
    .dma_mode (dma_mode),
    .irq_en   (irq_en),
    .trig_sel (trig_sel),
    .stat_rd  (stat_rd),
    .tx_rdy_n (tx_rdy_n),
    .tx_irq   (tx_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= pop;
  end

  assign stat_code = tx_irq ? txq_pkg::STAT_TXE : txq_pkg::STAT_NONE;

endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          pop_req,
  input logic          pop_valid,
  input logic          dma_mode,
  input logic          irq_en,
  input logic [1:0]    trig_sel,
  input logic          stat_rd,
  input logic          tx_rdy_n,
  input logic          tx_irq,
  input logic          tx_ovf,
  input logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] trig;
  assign trig = CW'(txq_pkg::trig_level(trig_sel, DEPTH));

  a_r1_bound: assert property (@(posedge clk) disable iff (rst) cnt <= FULL_CNT);

  a_r2_pop_valid: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt != '0) |=> pop_valid);

  a_r3_set_below: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_irq) && $stable(trig_sel)) |-> (cnt < trig));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !tx_irq);

  a_r5_refill_clears: assert property (@(posedge clk) disable iff (rst)
    ($stable(trig_sel) && cnt >= trig) |-> !tx_irq);

  a_r6_rdy_single: assert property (@(posedge clk) disable iff (rst)
    !$past(dma_mode) |-> (tx_rdy_n == (cnt != '0)));

  a_r7_rdy_block: assert property (@(posedge clk) disable iff (rst)
    $past(dma_mode) |-> (tx_rdy_n == (cnt == FULL_CNT)));

  a_r8_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cnt == FULL_CNT) |=> tx_ovf);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_ovf |=> tx_ovf);

  a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt == '0) |=> !pop_valid);

  a_r12_disabled: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !tx_irq);

endmodule

bind uart_txq_ctrl txq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .pop_req   (pop_req),
  .pop_valid (pop_valid),
  .dma_mode  (dma_mode),
  .irq_en    (irq_en),
  .trig_sel  (trig_sel),
  .stat_rd   (stat_rd),
  .tx_rdy_n  (tx_rdy_n),
  .tx_irq    (tx_irq),
  .tx_ovf    (tx_ovf),
  .cnt       (occ_cnt)
);

// File: tb/test_uart_txq_ctrl.sv
`timescale 1ns/1ps
module test_uart_txq_ctrl;

  logic       clk = 1'b0;
  logic       rst, wr_en, pop_req, dma_mode, irq_en, stat_rd;
  logic [7:0] wr_data, pop_data;
  logic [1:0] trig_sel;
  logic       pop_valid, tx_rdy_n, tx_irq, tx_ovf;
  logic [3:0] stat_code;

  always #4 clk = ~clk;

  uart_txq_ctrl i_uart_txq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
    .dma_mode(dma_mode), .irq_en(irq_en), .trig_sel(trig_sel),
    .stat_rd(stat_rd), .stat_code(stat_code), .tx_rdy_n(tx_rdy_n),
    .tx_irq(tx_irq), .tx_ovf(tx_ovf)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model
  logic [7:0] q[$];
  bit         m_pend, m_enq, m_ovf, m_pv, m_rdy_n, m_dma_prev;
  logic [7:0] m_pd;

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 24;
      default: return 30;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_pend = 0; m_enq = 0; m_ovf = 0; m_pv = 0; m_rdy_n = 0; m_dma_prev = 0;
  endtask

  task automatic model_step();
    int old_n, new_n, t;
    bit push_ok, pop_ok;
    old_n   = q.size();
    push_ok = wr_en && (old_n < 32);
    pop_ok  = pop_req && (old_n != 0);
    if (wr_en && old_n == 32) m_ovf = 1;
    m_pv = pop_ok;
    if (pop_ok) m_pd = q.pop_front();
    if (push_ok) q.push_back(wr_data);
    new_n = q.size();
    t = thr(trig_sel);
    if (stat_rd || !irq_en || new_n >= t) m_pend = 0;
    else if ((old_n >= t && new_n < t) || (irq_en && !m_enq)) m_pend = 1;
    m_enq = irq_en;
    m_rdy_n = dma_mode ? (new_n == 32) : (new_n != 0);
    m_dma_prev = dma_mode;
  endtask

  task automatic compare();
    chk(tx_rdy_n == m_rdy_n, m_dma_prev ? "R7 tx_rdy_n" : "R6 tx_rdy_n", tx_rdy_n, m_rdy_n);
    chk(tx_irq == m_pend, "R3 R4 R5 R12 tx_irq", tx_irq, m_pend);
    chk(tx_ovf == m_ovf, "R8 tx_ovf", tx_ovf, m_ovf);
    chk(pop_valid == m_pv, "R9 pop_valid", pop_valid, m_pv);
    if (m_pv) chk(pop_data == m_pd, "R2 pop_data", pop_data, m_pd);
    chk(stat_code == (m_pend ? 4'h2 : 4'h1), "R10 stat_code", stat_code, m_pend ? 2 : 1);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_en = 0; pop_req = 0; stat_rd = 0;
  endtask

  task automatic put(input int n);
    for (int i = 0; i < n; i++) begin
      idle(); wr_en = 1; wr_data = 8'($urandom); step();
    end
    idle();
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n; i++) begin
      idle(); pop_req = 1; step();
    end
    idle();
  endtask

  task automatic do_reset();
    idle(); rst = 1;
    @(posedge clk); @(posedge clk);
    model_reset();
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; idle(); wr_data = 0; dma_mode = 0; irq_en = 0; trig_sel = 0;
    do_reset();
    // R11 reset state
    chk(tx_rdy_n == 0 && tx_irq == 0 && tx_ovf == 0 && pop_valid == 0,
        "R11 reset outputs", {tx_rdy_n, tx_irq, tx_ovf, pop_valid}, 0);

    // R3 enable rise while empty; R4 status read clears
    irq_en = 1; step();
    chk(tx_irq == 1, "R3 enable rise below threshold", tx_irq, 1);
    stat_rd = 1; step(); idle();
    chk(tx_irq == 0, "R4 read clears", tx_irq, 0);

    // R5 refill clears
    irq_en = 0; step(); irq_en = 1; step();
    put(7);
    chk(tx_irq == 1, "R5 still pending below threshold", tx_irq, 1);
    put(1);
    chk(tx_irq == 0, "R5 refill to threshold clears", tx_irq, 0);
    chk(tx_rdy_n == 1, "R6 ready inactive when non-empty", tx_rdy_n, 1);

    // R1 fill to 32, R7 ready, R8 overflow
    dma_mode = 1; put(23);
    chk(tx_rdy_n == 0 && tx_ovf == 0, "R1 31 entries not full", tx_rdy_n, 0);
    put(1);
    chk(tx_rdy_n == 1, "R1 full after 32 writes", tx_rdy_n, 1);
    put(1);
    chk(tx_ovf == 1, "R8 overflow flagged", tx_ovf, 1);
    take(1);
    chk(tx_rdy_n == 0, "R7 ready with one free slot", tx_rdy_n, 0);

    // R4 read beats a crossing in the same cycle (count 8 -> 7)
    take(23);
    idle(); pop_req = 1; stat_rd = 1; step(); idle();
    chk(tx_irq == 0, "R4 read priority over crossing", tx_irq, 0);
    step();
    chk(tx_irq == 0, "R4 no late assertion", tx_irq, 0);
    put(1);
    // simultaneous push and pop at threshold keeps count
    idle(); wr_en = 1; pop_req = 1; wr_data = 8'h5a; step(); idle();
    chk(tx_irq == 0, "R3 steady count no crossing", tx_irq, 0);
    take(1);
    chk(tx_irq == 1, "R3 crossing sets", tx_irq, 1);

    // R12 disable clears
    irq_en = 0; step();
    chk(tx_irq == 0, "R12 disable clears", tx_irq, 0);
    irq_en = 1;
    take(10);
    chk(pop_valid == 0, "R9 empty pop invalid", pop_valid, 0);

    // R3 other thresholds
    dma_mode = 0;
    for (int s = 1; s < 4; s++) begin
      trig_sel = 2'(s);
      stat_rd = 1; step(); idle();
      put(thr(2'(s)) + 1);
      take(1);
      chk(tx_irq == 0, "R3 at threshold not set", tx_irq, 0);
      take(1);
      chk(tx_irq == 1, "R3 below threshold set", tx_irq, 1);
      take(40);
    end

    // Random segments
    for (int seg = 0; seg < 30; seg++) begin
      int wp;
      dma_mode = seg[0];
      trig_sel = 2'($urandom);
      wp = (seg % 3 == 0) ? 85 : ((seg % 3 == 1) ? 20 : 50);
      for (int c = 0; c < 150; c++) begin
        wr_en   = ($urandom % 100) < wp;
        wr_data = 8'($urandom);
        pop_req = ($urandom % 100) < 50;
        stat_rd = ($urandom % 16) == 0;
        irq_en  = ($urandom % 32) != 0;
        step();
      end
      idle();
    end

    // R11 reset clears sticky overflow
    put(40);
    do_reset();
    chk(tx_ovf == 0 && tx_rdy_n == 0 && tx_irq == 0, "R11 reset after use",
        {tx_ovf, tx_rdy_n, tx_irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule